// File: doc/BRIEF.md
# Programmable Step Rate Controller

This block times the commit of each step of a reconfigurable datapath. The storage registers and the program counter of that datapath run on a fast clock. The combinational network between them settles in a different number of fast cycles for each step, because each step's configuration builds a different chain of operations. The configuration of the active step therefore carries a wait count. The controller holds its commit enable low for that many fast cycles and then raises it for one cycle. That one-cycle enable gates the clock of the registers and the program counter, so results are written and the next step is fetched. Combinational cells never see the enable.

The result is a step period that software chooses per step: a short step commits after a few fast cycles and a deep step waits longer. A global stall freezes the count and holds the enable low. After reset, one cycle is spent loading the first step's wait count, and no commit can be issued in that cycle.

Top module: `srate_ctl`

## Requirements
- R1: While `rst` is high, and in the first cycle after `rst` falls (the load cycle), `commit_en` is 0.
- R2: With `step_wait` = N held from the load cycle onward and no stall, the first `commit_en` pulse comes N+1 cycles after the load cycle.
- R3: After a pulse, the next pulse comes N+1 cycles later, where N is the value of `step_wait` in the cycle right after the pulse (the reload cycle).
- R4: A wait count of 0 makes `commit_en` high in every non-stalled cycle after the load cycle.
- R5: Changes on `step_wait` after the reload cycle have no effect on the current step's period.
- R6: While `stall` is high, `commit_en` is 0 and the count is frozen, so each stalled cycle lengthens the step by exactly one cycle. A stall during the reload cycle delays the reload to the next non-stalled cycle.
- R7: `commit_en` is never high in two consecutive cycles unless `step_wait` is 0 in the second of them.
- R8: The largest wait count, 2^CNT_W - 1, gives a period of 2^CNT_W cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock shared with the datapath registers and program counter |
| rst | input | 1 | Synchronous active-high reset |
| step_wait | input | CNT_W | Wait count field of the active step configuration |
| stall | input | 1 | Global stall; freezes the count and holds the enable low |
| commit_en | output | 1 | One-cycle commit enable for the registers and program counter |

## Verification
The bench measures the distance in cycles between pulses, because an off-by-one in the count would show up only there. A design that sampled the wait field during the whole step, and not just in the reload cycle, would shorten a step when the field changes after the reload. Stalls are placed both mid-count and over the reload cycle: a design that kept counting under stall would commit early, and one that dropped the stalled reload would use the wrong wait count. Zero and full-scale counts are driven to catch a design that cannot pulse back to back, or one whose counter wraps.

// File: rtl/srate_pkg.sv
package srate_pkg;

    typedef enum logic [1:0] {
        PH_INIT   = 2'd0,
        PH_RELOAD = 2'd1,
        PH_COUNT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic   fire;
        logic   ld_full;
        logic   ld_less;
        logic   dec;
        phase_e nxt;
    } step_act_t;

    function automatic step_act_t idle_act(input phase_e cur);
        step_act_t a;
        a.fire    = 1'b0;
        a.ld_full = 1'b0;
        a.ld_less = 1'b0;
        a.dec     = 1'b0;
        a.nxt     = cur;
        return a;
    endfunction

endpackage

// File: rtl/srate_decide.sv
module srate_decide
    import srate_pkg::*;
(
    input  logic      rst,
    input  logic      stall,
    input  phase_e    phase,
    input  logic      wait_zero,
    input  logic      rem_zero,
    output step_act_t act
);

    always_comb begin
        act = idle_act(phase);
        if (!rst && !stall) begin
            unique case (phase)
                PH_INIT: begin
                    act.ld_full = 1'b1;
                    act.nxt     = PH_COUNT;
                end
                PH_RELOAD: begin
                    if (wait_zero) begin
                        act.fire = 1'b1;
                        act.nxt  = PH_RELOAD;
                    end else begin
                        act.ld_less = 1'b1;
                        act.nxt     = PH_COUNT;
                    end
                end
                PH_COUNT: begin
                    if (rem_zero) begin
                        act.fire = 1'b1;
                        act.nxt  = PH_RELOAD;
                    end else begin
                        act.dec = 1'b1;
                    end
                end
                default: act.nxt = PH_INIT;
            endcase
        end
    end

endmodule

// File: rtl/srate_phase.sv
module srate_phase
    import srate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  step_act_t act,
    output phase_e    phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_INIT;
        end else begin
            phase <= act.nxt;
        end
    end

endmodule

// File: rtl/srate_count.sv
module srate_count
    import srate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_act_t        act,
    input  logic [CNT_W-1:0] load_val,
    output logic             rem_zero
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (act.ld_full) begin
            rem <= load_val;
        end else if (act.ld_less) begin
            rem <= load_val - ONE;
        end else if (act.dec) begin
            rem <= rem - ONE;
        end
    end

    assign rem_zero = (rem == '0);

endmodule

// File: rtl/srate_ctl.sv
module srate_ctl
    import srate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] step_wait,
    input  logic             stall,
    output logic             commit_en
);

    phase_e    phase;
    step_act_t act;
    logic      rem_zero;
    logic      wait_zero;

    assign wait_zero = (step_wait == '0);

    srate_decide u_decide (
        .rst       (rst),
        .stall     (stall),
        .phase     (phase),
        .wait_zero (wait_zero),
        .rem_zero  (rem_zero),
        .act       (act)
    );

    srate_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .phase (phase)
    );

    srate_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .load_val (step_wait),
        .rem_zero (rem_zero)
    );

    assign commit_en = act.fire;

endmodule

// File: rtl/srate_ctl_chk.sv
module srate_ctl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] step_wait,
    input logic             stall,
    input logic             commit_en
);

    // R1: the load cycle after reset never commits
    a_r1_load_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !commit_en);

    // R6: stall forces the enable low
    a_r6_stall_low: assert property (@(posedge clk) disable iff (rst)
        stall |-> !commit_en);

    // R7: back-to-back pulses only with a zero wait count
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (commit_en && $past(commit_en)) |-> (step_wait == '0));

    // R3: a nonzero reload never commits in the reload cycle
    a_r3_reload_gap: assert property (@(posedge clk) disable iff (rst)
        ($past(commit_en) && !stall && step_wait != '0) |-> !commit_en);

    // R4: zero wait after a pulse commits again at once
    a_r4_zero_every: assert property (@(posedge clk) disable iff (rst)
        ($past(commit_en) && !stall && step_wait == '0) |-> commit_en);

endmodule

bind srate_ctl srate_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_wait (step_wait),
    .stall     (stall),
    .commit_en (commit_en)
);

// File: tb/sim_srate_ctl.sv
module sim_srate_ctl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] step_wait = '0;
    logic         stall = 1'b0;
    logic         commit_en;

    int n_chk  = 0;
    int n_bad  = 0;
    bit done   = 0;

    srate_ctl #(.CNT_W(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .step_wait (step_wait),
        .stall     (stall),
        .commit_en (commit_en)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at posedge+1, sample mid-cycle
    task automatic cyc(input logic [W-1:0] w, input logic s, output logic e);
        step_wait = w;
        stall     = s;
        #9;
        e = commit_en;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [W-1:0] w);
        logic e;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc(w, 1'b0, e);
            check(e == 1'b0, "R1 in reset", e, 0);
        end
        rst = 1'b0;
        cyc(w, 1'b0, e);
        check(e == 1'b0, "R1 load cycle", e, 0);
    endtask

    task automatic sync_pulse(input logic [W-1:0] w);
        logic e;
        for (int i = 0; i < 600; i++) begin
            cyc(w, 1'b0, e);
            if (e) return;
        end
        check(1'b0, "sync no pulse", 0, 1);
    endtask

    // cycles from the cycle after a pulse (k=1) up to the next pulse
    task automatic gap(input logic [W-1:0] w_first, input logic [W-1:0] w_rest,
                       input int st_from, input int st_len,
                       output int n, output int stall_hi);
        logic e;
        logic s;
        n = 0;
        stall_hi = 0;
        for (int k = 1; k < 700; k++) begin
            s = (k >= st_from) && (k < st_from + st_len);
            cyc((k == 1) ? w_first : w_rest, s, e);
            if (s && e) stall_hi++;
            if (e) begin
                n = k;
                return;
            end
        end
    endtask

    task automatic t_reset_first();
        logic e;
        int k;
        do_reset(8'd3);
        k = 0;
        for (int i = 1; i < 20; i++) begin
            cyc(8'd3, 1'b0, e);
            if (e) begin
                k = i;
                break;
            end
        end
        check(k == 4, "R2 first pulse wait=3", k, 4);
        cyc(8'd3, 1'b0, e);
        check(e == 1'b0, "R7 low after pulse", e, 0);
    endtask

    task automatic t_period();
        int n, sh;
        do_reset(8'd5);
        sync_pulse(8'd5);
        gap(8'd5, 8'd5, 0, 0, n, sh);
        check(n == 6, "R3 period wait=5", n, 6);
        gap(8'd2, 8'd2, 0, 0, n, sh);
        check(n == 3, "R3 period wait=2", n, 3);
        gap(8'd1, 8'd1, 0, 0, n, sh);
        check(n == 2, "R3 period wait=1", n, 2);
    endtask

    task automatic t_zero();
        logic e;
        int n, sh;
        do_reset(8'd0);
        cyc(8'd0, 1'b0, e);
        check(e == 1'b1, "R4 first cycle after load", e, 1);
        for (int i = 0; i < 5; i++) begin
            cyc(8'd0, 1'b0, e);
            check(e == 1'b1, "R4 every cycle", e, 1);
        end
        gap(8'd3, 8'd3, 0, 0, n, sh);
        check(n == 4, "R3 zero then wait=3", n, 4);
    endtask

    task automatic t_ignore();
        int n, sh;
        do_reset(8'd4);
        sync_pulse(8'd4);
        gap(8'd6, 8'd1, 0, 0, n, sh);
        check(n == 7, "R5 late change ignored (6 then 1)", n, 7);
        gap(8'd2, 8'd9, 0, 0, n, sh);
        check(n == 3, "R5 late change ignored (2 then 9)", n, 3);
    endtask

    task automatic t_stall();
        logic e;
        int n, sh;
        do_reset(8'd4);
        sync_pulse(8'd4);
        gap(8'd4, 8'd4, 2, 3, n, sh);
        check(n == 8, "R6 mid-count stall adds 3", n, 8);
        check(sh == 0, "R6 enable low under stall", sh, 0);
        // stall over the reload cycle with wait 0 presented
        cyc(8'd0, 1'b1, e);
        check(e == 1'b0, "R6 stalled reload low", e, 0);
        cyc(8'd0, 1'b0, e);
        check(e == 1'b1, "R6 reload after stall wait=0", e, 1);
        // stalled reload then nonzero wait
        gap(8'd7, 8'd2, 1, 1, n, sh);
        check(n == 4, "R6 stalled reload uses later value", n, 4);
    endtask

    task automatic t_max();
        int n, sh;
        do_reset(8'd255);
        sync_pulse(8'd255);
        gap(8'd255, 8'd255, 0, 0, n, sh);
        check(n == 256, "R8 full-scale period", n, 256);
    endtask

    initial begin
        @(posedge clk);
        #1;
        t_reset_first();
        t_period();
        t_zero();
        t_ignore();
        t_stall();
        t_max();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule